// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block collects eight active-low interrupt request lines from outside the chip. Each line first passes through a two-stage synchronizer. Software then chooses, line by line, whether a request is a low level or a high-to-low transition. Transition requests are held in a sticky pending bit until software clears them. Level requests track the synchronized pin.

An enable mask selects which pending lines may interrupt the processor. Line 0 is exempt from the mask and always interrupts. A fixed-priority encoder turns the surviving requests into an 8-bit vector code. The code is the winning line index multiplied by four, so its two low bits are always zero and software can use it directly as a jump-table offset. When nothing qualifies, the code is 0xFC.

A separate per-line wake enable drives a wake-up output that lets a power controller resume from a low-power state. Software reaches four 32-bit registers through a small read/write port. Reads can be byte, half-word or word sized. A narrow read returns the most significant byte or half-word of the register, right-aligned.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, every register reads zero except the vector, which reads 0xFC000000. `irq_o` and `wake_o` are 0.
- R2: With a line's transition-select bit at 0 (level mode), its pending bit is 1 exactly while the synchronized pin is low.
- R3: With a line's transition-select bit at 1, a high-to-low change on the pin sets its pending bit, and the bit stays set after the pin returns high.
- R4: Writing to the pending register (address 2) clears each transition-mode bit written as 1. Bits written as 0 are unchanged, and a level-mode bit is unaffected by the write.
- R5: If a new transition is detected on the same clock edge as a clear of that line, the pending bit ends up set.
- R6: The enable register (address 1, line i at word bit 31-i, 1 = enabled) keeps a disabled line 1..7 out of `irq_o` and the vector. The pending register still shows that line.
- R7: Line 0 raises `irq_o` and can win the vector whatever its enable bit holds.
- R8: The vector code is 4 times the lowest-numbered pending line that is enabled, or line 0 if it is pending. With no such line, the code is 0xFC. The code sits in vector-register bits 31:24, and bits 23:0 read zero.
- R9: `irq_o` is 1 exactly when at least one line qualifies under R8.
- R10: `wake_o` is 1 while any pending line has its wake bit set. The config register (address 0) holds line i's transition select at bit 31-2i and its wake enable at bit 30-2i.
- R11: `reg_size_i` selects the read width: 0 returns bits 31:24 in `rdata[7:0]`, 1 returns bits 31:16 in `rdata[15:0]`, and 2 or 3 returns the whole word. Unused upper bits of `rdata` read zero.
- R12: Reserved bits (config 15:0, enable and pending 23:0) read zero. Writes to the vector register (address 3) have no effect.
- R13: In level mode, a pin change made between clock edges shows in the pending register after the second rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n_i | input | 8 | External request lines, active low, asynchronous |
| reg_addr_i | input | 2 | Register select: 0 config, 1 enable, 2 pending, 3 vector |
| reg_wr_i | input | 1 | Word write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_size_i | input | 2 | Read width: 0 byte, 1 half-word, 2/3 word |
| reg_rdata_o | output | 32 | Read data, combinational from address and size |
| irq_o | output | 1 | Interrupt request to the processor |
| wake_o | output | 1 | Wake-up request to the power controller |
| vec_code_o | output | 8 | Current vector code |

## Verification
A software clear of a sticky pending bit can land on the same clock edge that a fresh high-to-low change is detected on that line. The bench provokes this by dropping the pin and then timing the clear write so that it commits on the third rising edge, which is when detection completes. It judges the outcome by reading the pending register back, where the bit must still be 1. The bench also sweeps every pin pattern and every enable pattern. For each, it compares the vector code and `irq_o` against a priority computed arithmetically in the bench.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned WORD_W    = 32;
  localparam logic [CODE_W-1:0] IDLE_CODE = 8'hFC;

  typedef enum logic [1:0] {
    RSEL_CFG  = 2'd0,
    RSEL_EN   = 2'd1,
    RSEL_PEND = 2'd2,
    RSEL_VEC  = 2'd3
  } rsel_e;

  typedef enum logic [1:0] {
    RSZ_BYTE = 2'd0,
    RSZ_HALF = 2'd1,
    RSZ_WORD = 2'd2,
    RSZ_WRD2 = 2'd3
  } rsize_e;
endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_n_i,
  output logic [W-1:0] sync_n_o
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  // Idle level of an active-low line is high, so both stages reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '1;
      stg2_q <= '1;
    end else begin
      stg1_q <= async_n_i;
      stg2_q <= stg1_q;
    end
  end

  assign sync_n_o = stg2_q;
endmodule

// File: rtl/irqv_detect.sv
module irqv_detect #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sync_n_i,
  input  logic [N-1:0] edge_sel_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] hold_q;
  logic [N-1:0] hold_d;
  logic [N-1:0] fall;

  for (genvar g = 0; g < N; g++) begin : g_line
    assign fall[g] = prev_q[g] & ~sync_n_i[g];

    // A newly detected transition takes precedence over a same-cycle clear.
    always_comb begin
      if (edge_sel_i[g]) begin
        hold_d[g] = fall[g] | (hold_q[g] & ~clr_i[g]);
      end else begin
        hold_d[g] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b1;
        hold_q[g] <= 1'b0;
      end else begin
        prev_q[g] <= sync_n_i[g];
        hold_q[g] <= hold_d[g];
      end
    end

    assign pend_o[g] = edge_sel_i[g] ? hold_q[g] : ~sync_n_i[g];
  end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
  import irqv_pkg::*;
#(
  parameter int unsigned N = NUM_LINES
) (
  input  logic [N-1:0]      act_i,
  output logic              any_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned PAD = CODE_W - IW - 2;

  logic [IW-1:0] idx;

  // Scan from the lowest priority upward so the lowest index wins.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) idx = IW'(i);
    end
  end

  assign any_o  = |act_i;
  assign code_o = any_o ? {{PAD{1'b0}}, idx, 2'b00} : IDLE_CODE;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned LINES = NUM_LINES,
  parameter int unsigned DW    = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_n_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic [1:0]        reg_size_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic [CODE_W-1:0] vec_code_o
);
  localparam int unsigned CFG_BITS = 2 * LINES;

  rsel_e  sel;
  rsize_e rsz;

  logic [LINES-1:0] edge_q, edge_d;
  logic [LINES-1:0] wake_q, wake_d;
  logic [LINES-1:0] en_q, en_d;
  logic [LINES-1:0] sync_n;
  logic [LINES-1:0] clr;
  logic [LINES-1:0] pend;
  logic [LINES-1:0] act;
  logic             cfg_we, en_we, pend_we;
  logic [DW-1:0]    word_rd;
  logic             unused_wdata;

  assign sel = rsel_e'(reg_addr_i);
  assign rsz = rsize_e'(reg_size_i);

  assign cfg_we  = reg_wr_i && (sel == RSEL_CFG);
  assign en_we   = reg_wr_i && (sel == RSEL_EN);
  assign pend_we = reg_wr_i && (sel == RSEL_PEND);

  assign unused_wdata = ^reg_wdata_i[DW-CFG_BITS-1:0];

  // Field extraction, MSB-first layout.
  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      edge_d[i] = reg_wdata_i[DW-1-2*i];
      wake_d[i] = reg_wdata_i[DW-2-2*i];
      en_d[i]   = reg_wdata_i[DW-1-i];
      clr[i]    = pend_we & reg_wdata_i[DW-1-i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      wake_q <= '0;
    end else if (cfg_we) begin
      edge_q <= edge_d;
      wake_q <= wake_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  irqv_sync #(.W(LINES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_n_i (irq_n_i),
    .sync_n_o  (sync_n)
  );

  irqv_detect #(.N(LINES)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_n_i   (sync_n),
    .edge_sel_i (edge_q),
    .clr_i      (clr),
    .pend_o     (pend)
  );

  // Line 0 bypasses the enable mask.
  assign act = pend & {en_q[LINES-1:1], 1'b1};

  irqv_prio #(.N(LINES)) u_prio (
    .act_i  (act),
    .any_o  (irq_o),
    .code_o (vec_code_o)
  );

  assign wake_o = |(pend & wake_q);

  // Full-word view of the selected register.
  always_comb begin
    word_rd = '0;
    unique case (sel)
      RSEL_CFG: begin
        for (int i = 0; i < LINES; i++) begin
          word_rd[DW-1-2*i] = edge_q[i];
          word_rd[DW-2-2*i] = wake_q[i];
        end
      end
      RSEL_EN: begin
        for (int i = 0; i < LINES; i++) word_rd[DW-1-i] = en_q[i];
      end
      RSEL_PEND: begin
        for (int i = 0; i < LINES; i++) word_rd[DW-1-i] = pend[i];
      end
      RSEL_VEC: begin
        word_rd[DW-1 -: CODE_W] = vec_code_o;
      end
      default: word_rd = '0;
    endcase
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (rsz)
      RSZ_BYTE: reg_rdata_o[7:0]  = word_rd[DW-1 -: 8];
      RSZ_HALF: reg_rdata_o[15:0] = word_rd[DW-1 -: 16];
      default:  reg_rdata_o       = word_rd;
    endcase
  end
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
  import irqv_pkg::*;
#(
  parameter int unsigned N = NUM_LINES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [N-1:0]      edge_sel,
  input logic [N-1:0]      pend,
  input logic              irq,
  input logic              wake,
  input logic [CODE_W-1:0] code
);
  a_r7_line0_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |-> irq);

  a_r8_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (code == IDLE_CODE));

  a_r8_code_form: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((code[1:0] == 2'b00) && (code < CODE_W'(4 * N))));

  a_r3_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && edge_sel[0] && pend[0]) |=> pend[0]);

  a_r10_wake_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (|pend));
endmodule

bind irq_vec_ctrl irqv_chk #(.N(LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr       (reg_wr_i),
  .edge_sel (edge_q),
  .pend     (pend),
  .irq      (irq_o),
  .wake     (wake_o),
  .code     (vec_code_o)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic [7:0]  irq_n;
  logic [1:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [1:0]  size;
  logic [31:0] rdata;
  logic        irq;
  logic        wake;
  logic [7:0]  code;

  int n_cmp;
  int n_err;
  bit done;

  irq_vec_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .irq_n_i (irq_n),
    .reg_addr_i (addr), .reg_wr_i (wr), .reg_wdata_i (wdata),
    .reg_size_i (size), .reg_rdata_o (rdata),
    .irq_o (irq), .wake_o (wake), .vec_code_o (code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] en_word(input logic [7:0] m);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++) r[31-i] = m[i];
    return r;
  endfunction

  function automatic logic [31:0] cfg_word(input logic [7:0] e, input logic [7:0] w);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      r[31-2*i] = e[i];
      r[30-2*i] = w[i];
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_code(input logic [7:0] a);
    logic [7:0] c = 8'hFC;
    for (int i = 7; i >= 0; i--) if (a[i]) c = 8'(i * 4);
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [1:0] s, output logic [31:0] d);
    addr = a; size = s;
    #1;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_cmp++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  a;
    n_cmp = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; irq_n = 8'hFF; addr = 2'd0; wr = 1'b0; wdata = '0; size = 2'd2;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    rd_reg(2'd0, 2'd2, d); chk("R1 cfg", d, 32'h0);
    rd_reg(2'd1, 2'd2, d); chk("R1 enable", d, 32'h0);
    rd_reg(2'd2, 2'd2, d); chk("R1 pending", d, 32'h0);
    rd_reg(2'd3, 2'd2, d); chk("R1 vector", d, 32'hFC00_0000);
    chk("R1 irq/wake", {30'b0, irq, wake}, 32'h0);

    // R13 synchronizer latency in level mode
    @(negedge clk); irq_n = 8'hF7;
    @(negedge clk); rd_reg(2'd2, 2'd2, d); chk("R13 after one edge", d, 32'h0);
    @(negedge clk); rd_reg(2'd2, 2'd2, d); chk("R13 after two edges", d, en_word(8'h08));
    irq_n = 8'hFF; wait_n(4);

    // R2 R8 R9: sweep all pin patterns with every line enabled
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1, 2'd2, d); chk("R12 enable reserved", d, 32'hFF00_0000);
    for (int p = 0; p < 256; p++) begin
      irq_n = ~8'(p);
      wait_n(3);
      rd_reg(2'd2, 2'd2, d); chk("R2 level pending", d, en_word(8'(p)));
      rd_reg(2'd3, 2'd2, d); chk("R8 vector sweep", d, {exp_code(8'(p)), 24'h0});
      chk("R9 irq sweep", {31'b0, irq}, {31'b0, |8'(p)});
    end

    // R6 R8 R9: sweep every enable pattern, lines 1..7 low, line 0 idle
    irq_n = 8'h01; wait_n(3);
    for (int m = 0; m < 256; m++) begin
      wr_reg(2'd1, en_word(8'(m)));
      a = 8'(m) & 8'hFE;
      rd_reg(2'd3, 2'd0, d); chk("R6 masked vector", d, {24'h0, exp_code(a)});
      chk("R9 irq mask", {31'b0, irq}, {31'b0, |a});
    end

    // R6 disabled line still pending
    wr_reg(2'd1, 32'h0);
    irq_n = 8'hDF; wait_n(3);
    rd_reg(2'd2, 2'd2, d); chk("R6 pending visible", d, en_word(8'h20));
    chk("R6 irq off", {31'b0, irq}, 32'h0);
    chk("R6 code idle", {24'h0, code}, 32'hFC);

    // R7 line 0 ignores its enable bit
    irq_n = 8'hDE; wait_n(3);
    chk("R7 nmi irq", {31'b0, irq}, 32'h1);
    chk("R7 nmi code", {24'h0, code}, 32'h0);
    irq_n = 8'hFF; wait_n(3);

    // R3 transition capture on line 2
    wr_reg(2'd0, cfg_word(8'h04, 8'h00));
    irq_n = 8'hFB; wait_n(2);
    irq_n = 8'hFF; wait_n(4);
    rd_reg(2'd2, 2'd2, d); chk("R3 sticky", d, en_word(8'h04));
    chk("R3 nmi-independent irq", {31'b0, irq}, 32'h0);

    // R4 clear semantics
    wr_reg(2'd2, 32'h0);
    rd_reg(2'd2, 2'd2, d); chk("R4 write zero keeps", d, en_word(8'h04));
    wr_reg(2'd2, en_word(8'h04));
    rd_reg(2'd2, 2'd2, d); chk("R4 write one clears", d, 32'h0);
    irq_n = 8'hEF; wait_n(3);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2, 2'd2, d); chk("R4 level unaffected", d, en_word(8'h10));
    irq_n = 8'hFF; wait_n(3);

    // R5 detection and clear on the same edge
    @(negedge clk); irq_n = 8'hFB;
    @(negedge clk);
    @(negedge clk); addr = 2'd2; wdata = en_word(8'h04); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rd_reg(2'd2, 2'd2, d); chk("R5 set wins", d, en_word(8'h04));
    irq_n = 8'hFF; wait_n(2);
    wr_reg(2'd2, en_word(8'h04));
    rd_reg(2'd2, 2'd2, d); chk("R5 later clear", d, 32'h0);

    // R10 wake output
    wr_reg(2'd0, cfg_word(8'h00, 8'h40));
    irq_n = 8'hFD; wait_n(3);
    chk("R10 no wake", {31'b0, wake}, 32'h0);
    irq_n = 8'hBD; wait_n(3);
    chk("R10 wake on", {31'b0, wake}, 32'h1);
    irq_n = 8'hFF; wait_n(3);
    chk("R10 wake off", {31'b0, wake}, 32'h0);

    // R11 read widths
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    irq_n = 8'hF7; wait_n(3);
    rd_reg(2'd3, 2'd0, d); chk("R11 byte", d, 32'h0000_000C);
    rd_reg(2'd3, 2'd1, d); chk("R11 half", d, 32'h0000_0C00);
    rd_reg(2'd3, 2'd2, d); chk("R11 word", d, 32'h0C00_0000);
    rd_reg(2'd3, 2'd3, d); chk("R11 word alt", d, 32'h0C00_0000);

    // R12 reserved bits and read-only vector
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, 2'd2, d); chk("R12 cfg reserved", d, 32'hFFFF_0000);
    rd_reg(2'd0, 2'd1, d); chk("R11 cfg half", d, 32'h0000_FFFF);
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd3, 32'h1234_5678);
    rd_reg(2'd3, 2'd2, d); chk("R12 vector read-only", d, 32'h0C00_0000);
    irq_n = 8'hFF; wait_n(3);
    rd_reg(2'd3, 2'd2, d); chk("R8 idle again", d, 32'hFC00_0000);

    finish_run();
  end
endmodule